// File: doc/BRIEF.md
# DRAM Fill and Eviction Handler

This block sits between the DRAM return path and a memory-side cache. It takes one returning transaction at a time and carries it to completion before it looks at the next one. Requests that were merged behind an earlier miss wait in a miss-merge chain. These merged requests are always served before fresh DRAM returns. When a read comes back, the block sends the reply to the requester, installs the line in the cache and writes back any dirty line that the install pushed out. Write returns need no data movement and are simply retired and counted.

The block is a five-state machine:

- **IDLE**: no transaction is held.
  - IDLE→SERVE when the chain head is popped.
  - IDLE→MERGE when a DRAM return is popped.
- **MERGE**: a DRAM return has just been popped and reported serviced.
  - MERGE→SERVE always. In this cycle, if the chain holds an entry, the chain head is popped and replaces the DRAM return.
- **SERVE**: the held transaction is acted on.
  - SERVE→IDLE for a write, which is retired.
  - SERVE→FILL for a read once the reply is pushed.
  - SERVE→SERVE while the reply queue is full.
- **FILL**: the line is installed and the victim address is captured.
  - FILL→IDLE when the victim is the all-ones "nothing to write back" value.
  - FILL→WBACK otherwise.
- **WBACK**: a full-line writeback is offered.
  - WBACK→IDLE on accept.
  - WBACK→WBACK on refusal.

All queues are seen as a head entry with a valid or non-empty flag and a pop strobe. The cache fill port returns the victim address combinationally in the same cycle as the fill strobe.

Top module: `dram_fill_handler`

## Requirements
- R1: In IDLE with the chain non-empty, the chain head is popped (`chain_pop`=1) and neither DRAM queue is popped in that cycle.
- R2: In IDLE with the chain empty, the read-return queue is popped when valid. The write-return queue is popped only when the read-return queue is empty.
- R3: A DRAM pop drives `svc_valid`=1 with `svc_addr` equal to the popped address in the same cycle. In the next cycle (MERGE) no DRAM queue is popped. If the chain is non-empty in that cycle, its head is popped and becomes the transaction that is replied to.
- R4: For a read, `reply_push` stays 0 while `reply_full`=1. Otherwise `reply_push`=1 with `reply_addr` equal to the transaction address, and in the next cycle `fill_req`=1 with `fill_addr` equal to the same address.
- R5: A victim of all ones (32'hFFFF_FFFF) means no writeback: `wb_req` stays 0 and the block is idle in the cycle after the fill.
- R6: Any other victim gives `wb_req`=1 in the cycle after the fill. This request carries `wb_addr` equal to the victim with its low 7 bits cleared, and `wb_size`=128. While `wb_accept`=0 it is repeated every cycle with the same address, and `reply_push` stays 0.
- R7: The cycle after `wb_accept`=1 with `wb_req`=1, the block is idle again and can pop a new transaction.
- R8: A write transaction is retired in its SERVE cycle without a reply or a fill, and `wr_retired_count` is one higher in the next cycle.
- R9: Whenever the block is idle, no victim is pending. A read that follows a completed writeback issues no writeback of its own when its victim is all ones.
- R10: At most one of `chain_pop`, `rdq_pop`, `wrq_pop`, `reply_push`, `fill_req` and `wb_req` is high in any cycle.
- R11: Synchronous active-high reset clears `wr_retired_count` and leaves all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_nonempty | input | 1 | Miss-merge chain has an entry |
| chain_head_addr | input | 32 | Address of chain head |
| chain_head_wr | input | 1 | Chain head is a write |
| chain_pop | output | 1 | Pop the chain head |
| rdq_valid | input | 1 | DRAM read-return queue has an entry |
| rdq_addr | input | 32 | Address at read-return head |
| rdq_pop | output | 1 | Pop read-return queue |
| wrq_valid | input | 1 | DRAM write-return queue has an entry |
| wrq_addr | input | 32 | Address at write-return head |
| wrq_pop | output | 1 | Pop write-return queue |
| svc_valid | output | 1 | Report a DRAM return as serviced to the miss tracker |
| svc_addr | output | 32 | Address of serviced return |
| reply_full | input | 1 | Reply queue cannot accept |
| reply_push | output | 1 | Push a reply |
| reply_addr | output | 32 | Reply address |
| fill_req | output | 1 | Install a line in the cache |
| fill_addr | output | 32 | Line address to install |
| fill_victim | input | 32 | Victim address returned by the fill, all ones if none |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | 32 | Line-aligned writeback address |
| wb_size | output | 8 | Writeback size in bytes |
| wb_accept | input | 1 | Writeback accepted this cycle |
| wr_retired_count | output | 16 | Count of retired write transactions |

## Verification
The chain and the DRAM queues can both offer work in the same cycle. This happens in two ways: in IDLE with a read return waiting, and in MERGE, straight after a DRAM pop, when the chain turns non-empty. The bench raises the chain flag together with a valid read-return head, or in the cycle after the pop. It then judges which pop strobe fires and which address later appears on `reply_addr`. A refused writeback also coincides with a waiting reply slot. Here the bench holds `wb_accept` low for several cycles and checks that `reply_push` never repeats.

// File: rtl/dfh_pkg.sv
package dfh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MERGE,
        ST_SERVE,
        ST_FILL,
        ST_WBACK
    } dfh_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CHAIN,
        SRC_RDQ,
        SRC_WRQ
    } dfh_src_e;
endpackage

// File: rtl/dfh_source_sel.sv
module dfh_source_sel
    import dfh_pkg::*;
(
    input  dfh_state_e state,
    input  logic       chain_nonempty,
    input  logic       rdq_valid,
    input  logic       wrq_valid,
    output dfh_src_e   src
);
    // Chain outranks DRAM; in MERGE only the chain may be taken.
    always_comb begin
        src = SRC_NONE;
        if ((state == ST_IDLE || state == ST_MERGE) && chain_nonempty)
            src = SRC_CHAIN;
        else if (state == ST_IDLE && rdq_valid)
            src = SRC_RDQ;
        else if (state == ST_IDLE && wrq_valid)
            src = SRC_WRQ;
    end
endmodule

// File: rtl/dfh_victim_reg.sv
module dfh_victim_reg #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              clear,
    output logic              pending,
    output logic [ADDR_W-1:0] line_addr
);
    localparam logic [ADDR_W-1:0] NO_VICTIM = '1;

    logic [ADDR_W-1:0] victim_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            victim_q <= NO_VICTIM;
        else if (load)
            victim_q <= load_val;
    end

    assign pending   = (victim_q != NO_VICTIM);
    assign line_addr = {victim_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/dfh_retire_cnt.sv
module dfh_retire_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/dram_fill_handler.sv
module dram_fill_handler
    import dfh_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int CNT_W      = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            chain_nonempty,
    input  logic [ADDR_W-1:0]               chain_head_addr,
    input  logic                            chain_head_wr,
    output logic                            chain_pop,
    input  logic                            rdq_valid,
    input  logic [ADDR_W-1:0]               rdq_addr,
    output logic                            rdq_pop,
    input  logic                            wrq_valid,
    input  logic [ADDR_W-1:0]               wrq_addr,
    output logic                            wrq_pop,
    output logic                            svc_valid,
    output logic [ADDR_W-1:0]               svc_addr,
    input  logic                            reply_full,
    output logic                            reply_push,
    output logic [ADDR_W-1:0]               reply_addr,
    output logic                            fill_req,
    output logic [ADDR_W-1:0]               fill_addr,
    input  logic [ADDR_W-1:0]               fill_victim,
    output logic                            wb_req,
    output logic [ADDR_W-1:0]               wb_addr,
    output logic [$clog2(LINE_BYTES):0]     wb_size,
    input  logic                            wb_accept,
    output logic [CNT_W-1:0]                wr_retired_count
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SIZE_W = OFF_W + 1;
    localparam logic [ADDR_W-1:0] NO_VICTIM = '1;

    dfh_state_e        state, state_nx;
    dfh_src_e          src;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_wr;
    logic              vic_pending;
    logic              retire;

    dfh_source_sel u_sel (
        .state          (state),
        .chain_nonempty (chain_nonempty),
        .rdq_valid      (rdq_valid),
        .wrq_valid      (wrq_valid),
        .src            (src)
    );

    dfh_victim_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_vic (
        .clk       (clk),
        .rst       (rst),
        .load      (fill_req),
        .load_val  (fill_victim),
        .clear     (wb_req && wb_accept),
        .pending   (vic_pending),
        .line_addr (wb_addr)
    );

    dfh_retire_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (retire),
        .count (wr_retired_count)
    );

    // State and in-progress transaction register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            cur_wr   <= 1'b0;
        end else begin
            state <= state_nx;
            unique case (src)
                SRC_CHAIN: begin cur_addr <= chain_head_addr; cur_wr <= chain_head_wr; end
                SRC_RDQ:   begin cur_addr <= rdq_addr;        cur_wr <= 1'b0;          end
                SRC_WRQ:   begin cur_addr <= wrq_addr;        cur_wr <= 1'b1;          end
                default:   ;
            endcase
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (src == SRC_CHAIN)
                    state_nx = ST_SERVE;
                else if (src == SRC_RDQ || src == SRC_WRQ)
                    state_nx = ST_MERGE;
            end
            ST_MERGE: state_nx = ST_SERVE;
            ST_SERVE: begin
                if (cur_wr)
                    state_nx = ST_IDLE;
                else if (!reply_full)
                    state_nx = ST_FILL;
            end
            ST_FILL:  state_nx = (fill_victim == NO_VICTIM) ? ST_IDLE : ST_WBACK;
            ST_WBACK: if (wb_accept) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        chain_pop  = (src == SRC_CHAIN);
        rdq_pop    = (src == SRC_RDQ);
        wrq_pop    = (src == SRC_WRQ);
        svc_valid  = rdq_pop || wrq_pop;
        svc_addr   = rdq_pop ? rdq_addr : wrq_addr;
        reply_push = (state == ST_SERVE) && !cur_wr && !reply_full;
        reply_addr = cur_addr;
        retire     = (state == ST_SERVE) && cur_wr;
        fill_req   = (state == ST_FILL);
        fill_addr  = cur_addr;
        wb_req     = (state == ST_WBACK);
        wb_size    = SIZE_W'(LINE_BYTES);
    end

    // Assertions
    a_r1_chain_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && chain_nonempty) |-> (chain_pop && !rdq_pop && !wrq_pop));
    a_r2_read_first: assert property (@(posedge clk) disable iff (rst)
        wrq_pop |-> !rdq_valid);
    a_r3_no_dram_in_merge: assert property (@(posedge clk) disable iff (rst)
        svc_valid |=> (!rdq_pop && !wrq_pop));
    a_r4_no_push_full: assert property (@(posedge clk) disable iff (rst)
        reply_push |-> !reply_full);
    a_r4_fill_follows: assert property (@(posedge clk) disable iff (rst)
        reply_push |=> (fill_req && fill_addr == $past(reply_addr)));
    a_r5_no_victim_idle: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_victim == NO_VICTIM) |=> (!wb_req && !vic_pending));
    a_r6_retry: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_accept) |=> (wb_req && $stable(wb_addr) && !reply_push));
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        retire |=> (wr_retired_count == $past(wr_retired_count) + CNT_W'(1)));
    a_r9_idle_clean: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !vic_pending);
    a_r10_one_action: assert property (@(posedge clk) disable iff (rst)
        $countones({chain_pop, rdq_pop, wrq_pop, reply_push, fill_req, wb_req}) <= 1);
endmodule

// File: tb/test_dram_fill_handler.sv
module test_dram_fill_handler;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chain_nonempty = 1'b0;
    logic [31:0] chain_head_addr = '0;
    logic        chain_head_wr = 1'b0;
    logic        chain_pop;
    logic        rdq_valid = 1'b0;
    logic [31:0] rdq_addr = '0;
    logic        rdq_pop;
    logic        wrq_valid = 1'b0;
    logic [31:0] wrq_addr = '0;
    logic        wrq_pop;
    logic        svc_valid;
    logic [31:0] svc_addr;
    logic        reply_full = 1'b0;
    logic        reply_push;
    logic [31:0] reply_addr;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic [31:0] fill_victim = 32'hFFFF_FFFF;
    logic        wb_req;
    logic [31:0] wb_addr;
    logic [7:0]  wb_size;
    logic        wb_accept = 1'b0;
    logic [15:0] wr_retired_count;

    int n_run  = 0;
    int n_fail = 0;
    int n_multi = 0;
    int exp_wr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_fill_handler i_dram_fill_handler (.*);

    always @(negedge clk)
        if (!rst && ($countones({chain_pop, rdq_pop, wrq_pop, reply_push, fill_req, wb_req}) > 1))
            n_multi++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Read popped from the read queue, sentinel victim, no chain activity.
    task automatic read_basic(input logic [31:0] a);
        rdq_valid = 1'b1; rdq_addr = a; #1;
        chk("R2", "rdq_pop", 32'(rdq_pop), 1);
        chk("R3", "svc_addr", svc_addr, a);
        tick(); rdq_valid = 1'b0; #1;
        chk("R3", "merge no pop", 32'({rdq_pop, wrq_pop, chain_pop}), 0);
        tick(); #1;
        chk("R4", "reply_addr", reply_push ? reply_addr : 32'hDEAD_0000, a);
        tick(); fill_victim = 32'hFFFF_FFFF; #1;
        chk("R4", "fill_addr", fill_req ? fill_addr : 32'hDEAD_0001, a);
        tick(); #1;
        chk("R5", "no wb", 32'(wb_req), 0);
    endtask

    task automatic t_reset();
        chk("R11", "count", 32'(wr_retired_count), 0);
        chk("R11", "strobes", 32'({chain_pop, rdq_pop, wrq_pop, svc_valid, reply_push, fill_req, wb_req}), 0);
    endtask

    task automatic t_reply_backpressure();
        rdq_valid = 1'b1; rdq_addr = 32'h0000_1000; #1;
        chk("R3", "svc_valid", 32'(svc_valid), 1);
        tick(); rdq_valid = 1'b0;
        tick(); reply_full = 1'b1; #1;
        chk("R4", "held while full", 32'(reply_push), 0);
        tick(); #1;
        chk("R4", "still held", 32'({reply_push, fill_req}), 0);
        reply_full = 1'b0; #1;
        chk("R4", "push when free", 32'(reply_push), 1);
        chk("R4", "reply addr", reply_addr, 32'h0000_1000);
        tick(); #1;
        chk("R4", "fill next", 32'(fill_req), 1);
        tick(); #1;
        chk("R5", "idle after sentinel", 32'({wb_req, fill_req, reply_push}), 0);
    endtask

    task automatic t_victim_retry();
        rdq_valid = 1'b1; rdq_addr = 32'h0000_2000;
        tick(); rdq_valid = 1'b0;
        tick(); #1;
        chk("R4", "reply", 32'(reply_push), 1);
        tick(); fill_victim = 32'h1234_56F7; #1;
        chk("R4", "fill", 32'(fill_req), 1);
        tick(); fill_victim = 32'hFFFF_FFFF; wb_accept = 1'b0; #1;
        chk("R6", "wb_req", 32'(wb_req), 1);
        chk("R6", "wb_addr", wb_addr, 32'h1234_5680);
        chk("R6", "wb_size", 32'(wb_size), 128);
        for (int i = 0; i < 3; i++) begin
            tick(); #1;
            chk("R6", "retry wb_req", 32'(wb_req), 1);
            chk("R6", "retry addr", wb_addr, 32'h1234_5680);
            chk("R6", "no reply resend", 32'(reply_push), 0);
        end
        wb_accept = 1'b1;
        tick(); wb_accept = 1'b0; #1;
        chk("R7", "idle after accept", 32'(wb_req), 0);
        rdq_valid = 1'b1; rdq_addr = 32'h0000_2100; #1;
        chk("R7", "new pop", 32'(rdq_pop), 1);
        rdq_valid = 1'b0; #1;
        read_basic(32'h0000_2200);
        chk("R9", "no stale wb", 32'(wb_req), 0);
    endtask

    task automatic t_write_retire();
        wrq_valid = 1'b1; wrq_addr = 32'h0000_3000; #1;
        chk("R2", "wrq_pop", 32'(wrq_pop), 1);
        chk("R3", "svc write addr", svc_addr, 32'h0000_3000);
        tick(); wrq_valid = 1'b0;
        tick(); #1;
        chk("R8", "no reply", 32'({reply_push, fill_req}), 0);
        tick(); exp_wr++; #1;
        chk("R8", "count", 32'(wr_retired_count), 32'(exp_wr));
        chk("R8", "no fill", 32'({fill_req, wb_req}), 0);
    endtask

    task automatic t_read_over_write();
        rdq_valid = 1'b1; rdq_addr = 32'h0000_4000;
        wrq_valid = 1'b1; wrq_addr = 32'h0000_4800; #1;
        chk("R2", "read wins", 32'({rdq_pop, wrq_pop}), 32'b10);
        tick(); rdq_valid = 1'b0; #1;
        chk("R3", "no write pop in merge", 32'(wrq_pop), 0);
        tick(); #1;
        chk("R2", "reply is read", reply_addr, 32'h0000_4000);
        tick(); tick(); #1;
        chk("R2", "write now", 32'(wrq_pop), 1);
        tick(); wrq_valid = 1'b0;
        tick(); tick(); exp_wr++; #1;
        chk("R8", "count after second", 32'(wr_retired_count), 32'(exp_wr));
    endtask

    task automatic t_chain_first();
        chain_nonempty = 1'b1; chain_head_addr = 32'h0000_5000; chain_head_wr = 1'b0;
        rdq_valid = 1'b1; rdq_addr = 32'h0000_5800; #1;
        chk("R1", "chain pop", 32'({chain_pop, rdq_pop, wrq_pop}), 32'b100);
        tick(); chain_nonempty = 1'b0; #1;
        chk("R1", "reply chain addr", reply_push ? reply_addr : 32'hDEAD_0002, 32'h0000_5000);
        tick(); tick(); #1;
        chk("R1", "then read pop", 32'(rdq_pop), 1);
        tick(); rdq_valid = 1'b0;
        tick(); #1;
        chk("R1", "read reply", reply_addr, 32'h0000_5800);
        tick(); tick();
    endtask

    task automatic t_merge_replace();
        rdq_valid = 1'b1; rdq_addr = 32'h0000_6000;
        tick(); rdq_valid = 1'b0;
        chain_nonempty = 1'b1; chain_head_addr = 32'h0000_6400; chain_head_wr = 1'b0; #1;
        chk("R3", "chain pop in merge", 32'(chain_pop), 1);
        tick(); chain_nonempty = 1'b0; #1;
        chk("R3", "replaced reply", reply_push ? reply_addr : 32'hDEAD_0003, 32'h0000_6400);
        tick(); #1;
        chk("R3", "fill replaced", fill_addr, 32'h0000_6400);
        tick(); #1;
    endtask

    initial begin
        tick(); tick();
        rst = 1'b0; #1;
        t_reset();
        read_basic(32'h0000_0080);
        t_reply_backpressure();
        t_victim_retry();
        t_write_retire();
        t_read_over_write();
        t_chain_first();
        t_merge_replace();
        chk("R10", "single action per cycle", 32'(n_multi), 0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule